// File: doc/BRIEF.md
# Pipelined Binary Adder Tree

This block reduces a set of N signed two's-complement operands to a single signed total. It is the summation stage that sits behind a bank of parallel tap multipliers.

The operands arrive on one packed bus, one full vector per clock. They are combined pairwise in a fully registered binary tree. Each register stage holds at most one two-input adder, so the combinational depth per stage is a single addition whatever the operand count.

The operand count may be any positive integer. Where a level has an odd number of operands, the unpaired one passes through a plain register, so that every path through the tree has the same latency. Each level sign-extends its operands by one bit before adding, so the final sum can never overflow.

The depth defaults to ceil(log2 N). A larger depth may be chosen; the extra levels are single-operand delay stages. With N = 1 the default depth is zero and the block is a combinational wire.

Top module: `pipe_adder_tree`

## Requirements
- R1: `sum_o` equals the exact two's-complement sum of all N_IN signed IN_W-bit operands. Operand i occupies bits [i*IN_W +: IN_W] of `opnd_i`.
- R2: A new operand vector is accepted on every rising clock edge. Its sum appears on `sum_o` exactly DEPTH rising edges after the edge that captured it. Back-to-back vectors do not interfere with each other.
- R3: `sum_o` is IN_W+DEPTH bits wide and never overflows. In particular, a vector with every operand at the most positive value, or every operand at the most negative value, yields the exact sum.
- R4: Operand counts that are not powers of two (for example 5, 6 and 21) produce the exact sum with the same DEPTH latency. An unpaired operand at a level passes through a delay register and is not lost.
- R5: While `rst_ni` is low, every pipeline register is cleared asynchronously and `sum_o` reads zero. After release, the outputs for the first DEPTH edges are the zeros flushed out of the cleared pipeline.
- R6: With N_IN = 1 and the default DEPTH of 0, `sum_o` is `opnd_i` passed straight through with no register, and its width is IN_W.
- R7: A DEPTH greater than ceil(log2 N_IN) adds single-operand delay stages, each one bit wider than the last. The exact sum then appears after DEPTH edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opnd_i | input | N_IN*IN_W | Packed signed operands, operand i at [i*IN_W +: IN_W] |
| sum_o | output | IN_W+DEPTH | Signed sum of the vector captured DEPTH edges earlier |

## Verification
The bench runs operand counts of 1, 2, 5, 6, 8 and 21, plus a tree deeper than it needs to be, and checks each against a delayed behavioural sum on every cycle.

- **Unpaired operands.** A tree that drops an unpaired operand, or gives it one register too few, shows up in the odd counts: their sums come out short or skewed by a cycle.
- **Bit growth.** Vectors with every operand at the most positive or most negative value expose a level that misses a bit of growth or zero-extends a negative value; the total then wraps or flips sign.
- **Reset.** A reset applied mid-stream must zero the output at once and flush zeros. A design with synchronous reset or a stale stage would show old sums.
- **Single operand.** The N = 1 case catches a pipeline that inserts a register where none belongs.

// File: rtl/adder_tree_pkg.sv
package adder_tree_pkg;

  // Node count after lvl pairwise reductions of n operands.
  function automatic int nodes_at(input int n, input int lvl);
    int r;
    r = n;
    for (int k = 0; k < lvl; k++) r = (r + 1) / 2;
    return r;
  endfunction

endpackage

// File: rtl/adder_tree_node.sv
module adder_tree_node #(
  parameter int W   = 8,
  parameter int OPS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPS*W-1:0] op_i,
  output logic [W:0]       sum_o
);

  logic signed [W-1:0] a;
  logic                armed_q;

  assign a = op_i[W-1:0];

  // Checker-only: high once the result register holds a computed value.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  if (OPS == 2) begin : g_add
    logic signed [W-1:0] b;
    assign b = op_i[2*W-1:W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_o <= '0;
      else         sum_o <= {a[W-1], a} + {b[W-1], b};
    end

    assert_no_overflow_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      ($past(a) < 0 && $past(b) < 0) |-> ($signed(sum_o) < 0));

    assert_no_wrap_pos_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      ($past(a) >= 0 && $past(b) >= 0) |-> ($signed(sum_o) >= 0));
  end else begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_o <= '0;
      else         sum_o <= {a[W-1], a};
    end

    assert_lone_sign_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      ($past(a) < 0) |-> ($signed(sum_o) < 0));
  end

endmodule

// File: rtl/adder_tree_level.sv
module adder_tree_level #(
  parameter  int N_OPS = 5,
  parameter  int W     = 8,
  localparam int N_OUT = (N_OPS + 1) / 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_OPS*W-1:0]   op_i,
  output logic [N_OUT*(W+1)-1:0] sum_o
);

  for (genvar j = 0; j < N_OUT; j++) begin : g_node
    if (2*j + 1 < N_OPS) begin : g_pair
      adder_tree_node #(.W(W), .OPS(2)) u_node (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_i   (op_i[2*j*W +: 2*W]),
        .sum_o  (sum_o[j*(W+1) +: W+1])
      );
    end else begin : g_lone
      adder_tree_node #(.W(W), .OPS(1)) u_node (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_i   (op_i[2*j*W +: W]),
        .sum_o  (sum_o[j*(W+1) +: W+1])
      );
    end
  end

endmodule

// File: rtl/pipe_adder_tree.sv
module pipe_adder_tree
  import adder_tree_pkg::*;
#(
  parameter  int N_IN  = 8,
  parameter  int IN_W  = 16,
  parameter  int DEPTH = $clog2(N_IN),
  localparam int OUT_W = IN_W + DEPTH
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_IN*IN_W-1:0] opnd_i,
  output logic [OUT_W-1:0]     sum_o
);

  if (DEPTH == 0) begin : g_bypass
    // Single operand: no stage, no register (R6).
    assign sum_o = opnd_i;
  end else begin : g_tree
    for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
      localparam int NI = nodes_at(N_IN, l);
      localparam int NO = nodes_at(N_IN, l + 1);
      localparam int WI = IN_W + l;

      logic [NI*WI-1:0]     d;
      logic [NO*(WI+1)-1:0] q;

      if (l == 0) begin : g_src
        assign d = opnd_i;
      end else begin : g_src
        assign d = g_lvl[l-1].q;
      end

      adder_tree_level #(.N_OPS(NI), .W(WI)) u_lvl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_i   (d),
        .sum_o  (q)
      );
    end

    assign sum_o = g_lvl[DEPTH-1].q;

    // End-to-end reference: flat sum delayed DEPTH cycles.
    logic signed [OUT_W-1:0] ref_now;
    logic        [OUT_W-1:0] ref_q [DEPTH];
    int unsigned             fill_q;

    always_comb begin
      ref_now = '0;
      for (int i = 0; i < N_IN; i++)
        ref_now = ref_now + OUT_W'($signed(opnd_i[i*IN_W +: IN_W]));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fill_q <= 0;
        for (int k = 0; k < DEPTH; k++) ref_q[k] <= '0;
      end else begin
        if (fill_q < DEPTH) fill_q <= fill_q + 1;
        ref_q[0] <= ref_now;
        for (int k = 1; k < DEPTH; k++) ref_q[k] <= ref_q[k-1];
      end
    end

    // Covers R1 as well.
    assert_sum_latency_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fill_q == DEPTH) |-> (sum_o == ref_q[DEPTH-1]));

    always @(posedge clk_i) begin
      if (!rst_ni) assert_reset_zero_R5 : assert (sum_o == '0);
    end
  end

endmodule

// File: tb/tb_pipe_adder_tree.sv
`timescale 1ns/1ps

module adder_tree_probe #(
  parameter int    N   = 5,
  parameter int    W   = 8,
  parameter int    D   = 3,
  parameter string TAG = "R1"
) (
  input  logic clk,
  input  logic rst_n,
  input  int   mode,
  output int   n_chk,
  output int   n_fail
);
  localparam int OW = W + D;

  logic [N*W-1:0] vec;
  logic [OW-1:0]  sum;
  int             hist[$];

  pipe_adder_tree #(.N_IN(N), .IN_W(W), .DEPTH(D)) dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .opnd_i (vec),
    .sum_o  (sum)
  );

  initial begin
    n_chk  = 0;
    n_fail = 0;
    vec    = '0;
    forever begin
      int s, act, exp_v, vmax, vmin;
      string tag;
      @(negedge clk);
      vmax = (1 << (W-1)) - 1;
      vmin = -(1 << (W-1));
      s = 0;
      for (int i = 0; i < N; i++) begin
        int v;
        case (mode)
          0:       v = int'($urandom_range(0, (1 << W) - 1)) + vmin;
          1:       v = vmax;
          2:       v = vmin;
          default: v = (i % 2 == 1) ? vmax : vmin;
        endcase
        vec[i*W +: W] = v[W-1:0];
        s += v;
      end
      if (!rst_n) hist.delete();
      hist.push_front(rst_n ? s : 0);
      while (hist.size() > D + 1) void'(hist.pop_back());
      #1;
      if (D == 0)           exp_v = s;
      else if (!rst_n)      exp_v = 0;
      else if (hist.size() > D) exp_v = hist[D];
      else                  exp_v = 0;
      act = int'($signed(sum));
      if (!rst_n && D > 0)            tag = "R5";
      else if (mode == 1 || mode == 2) tag = "R3";
      else                            tag = TAG;
      n_chk++;
      if (act != exp_v) begin
        n_fail++;
        $display("FAIL %s N=%0d D=%0d mode=%0d: actual %0d expected %0d",
                 tag, N, D, mode, act, exp_v);
      end
    end
  end
endmodule

module tb_pipe_adder_tree;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   mode = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  int c[7];
  int f[7];

  adder_tree_probe #(.N(1),  .W(8), .D(0), .TAG("R6")) u_n1  (.clk(clk), .rst_n(rst_n), .mode(mode), .n_chk(c[0]), .n_fail(f[0]));
  adder_tree_probe #(.N(2),  .W(8), .D(1), .TAG("R2")) u_n2  (.clk(clk), .rst_n(rst_n), .mode(mode), .n_chk(c[1]), .n_fail(f[1]));
  adder_tree_probe #(.N(5),  .W(8), .D(3), .TAG("R4")) u_n5  (.clk(clk), .rst_n(rst_n), .mode(mode), .n_chk(c[2]), .n_fail(f[2]));
  adder_tree_probe #(.N(6),  .W(8), .D(3), .TAG("R4")) u_n6  (.clk(clk), .rst_n(rst_n), .mode(mode), .n_chk(c[3]), .n_fail(f[3]));
  adder_tree_probe #(.N(8),  .W(8), .D(3), .TAG("R2")) u_n8  (.clk(clk), .rst_n(rst_n), .mode(mode), .n_chk(c[4]), .n_fail(f[4]));
  adder_tree_probe #(.N(21), .W(8), .D(5), .TAG("R1")) u_n21 (.clk(clk), .rst_n(rst_n), .mode(mode), .n_chk(c[5]), .n_fail(f[5]));
  adder_tree_probe #(.N(5),  .W(8), .D(4), .TAG("R7")) u_deep(.clk(clk), .rst_n(rst_n), .mode(mode), .n_chk(c[6]), .n_fail(f[6]));

  task automatic report(input int extra_fail);
    int tot, bad;
    tot = extra_fail;
    bad = extra_fail;
    for (int k = 0; k < 7; k++) begin
      tot += c[k];
      bad += f[k];
    end
    $display("%0d/%0d checks passed", tot - bad, tot);
  endtask

  task automatic run(input int m, input int cycles);
    mode = m;
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    run(0, 200);   // R1 R2 R4 random streams
    run(1, 20);    // R3 all most-positive
    run(2, 20);    // R3 all most-negative
    run(3, 20);    // alternating extremes
    run(0, 50);
    rst_n = 1'b0;  // R5 mid-stream async reset
    run(0, 3);
    rst_n = 1'b1;
    run(0, 100);
    run(2, 10);
    run(0, 10);
    done = 1'b1;
    report(0);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      $display("FAIL watchdog: actual timeout expected completion");
      report(1);
      $finish;
    end
  end
endmodule